// File: doc/BRIEF.md
# Open-Drain Packet Sender with Attention-Line Arbitration

This block puts a length-framed packet onto a single shared data wire that every node drives open-drain. A logic one is sent by letting go of the wire so that the external pull-up raises it, and a logic zero by pulling the wire low. Because any node can pull the wire low, every released data bit is read back at mid-bit. A low reading means another sender is active, so the packet is abandoned as a collision.

A second shared wire, the attention line, guards access to the bus. When `start` arrives the block looks at the attention line while leaving it undriven. If the line is already low, the attempt ends at once as bus-busy. Otherwise the block pulls the attention line low, waits three bit periods, and sends the bytes. Each byte is preceded by one released gap bit. The first byte holds the length field L, and the block sends L+2 bytes in total: the length byte, L payload bytes, and one trailing check byte. It reads them from a byte-array port at addresses 0 upward. Each attempt ends with a one-cycle `done` pulse carrying a status code, and one of three 16-bit event counters advances.

Top module: `od_pkt_tx`

## Requirements
- R1: If `attn_in` is low in the cycle where `start` is accepted in idle, the edge that accepts `start` raises `done` with `status` = 2'b01 (busy). Neither `attn_drive_low` nor `line_drive_low` is ever asserted for that attempt.
- R2: If `attn_in` is high on acceptance, `attn_drive_low` is high from the accepting edge until the edge that raises `done`. At that edge it returns low, for success and for collision alike.
- R3: After acceptance the data line stays released for 3·BIT_CYCLES cycles. Every byte then begins with one released gap bit period.
- R4: Each byte after its gap is sent as a start bit (line driven low), then eight data bits least significant first (driven low for 0, released for 1), then a released stop bit. Every bit lasts BIT_CYCLES cycles.
- R5: The byte at address 0 is the length L. Bytes are read from addresses 0, 1, … L+1 in order, so exactly L+2 bytes are framed.
- R6: For a released data bit, `line_in` is sampled in the cycle BIT_CYCLES/2 cycles into that bit. If it reads low, the following edge ends the packet with `done`, `status` = 2'b10 (collision), and both lines released.
- R7: A packet with no collision ends with `done` and `status` = 2'b00 at the edge that closes the last stop bit, which is 3·BIT_CYCLES + 11·BIT_CYCLES·(L+2) edges after acceptance. `done` is high for exactly one cycle.
- R8: `cnt_ok`, `cnt_busy` and `cnt_coll` each count up by one at the `done` edge of an attempt whose status is ok, busy or collision respectively, and are otherwise unchanged.
- R9: `start` has no effect while an attempt is in progress: the wire image, the end time, the status and the counters are the same as without it.
- R10: After reset both lines are released, `busy`, `done` and `status` are zero, and all three counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send the packet held in the byte array |
| mem_addr | output | LEN_W+1 | Byte-array read address |
| mem_data | input | 8 | Byte at `mem_addr`, combinational read |
| attn_in | input | 1 | Level seen on the attention wire |
| attn_drive_low | output | 1 | Pull the attention wire low |
| line_in | input | 1 | Level seen on the data wire |
| line_drive_low | output | 1 | Pull the data wire low |
| busy | output | 1 | Attempt in progress |
| done | output | 1 | One-cycle end-of-attempt pulse |
| status | output | 2 | 00 ok, 01 busy, 10 collision; valid with `done` |
| cnt_ok | output | CNT_W | Packets sent |
| cnt_busy | output | CNT_W | Attempts refused as bus-busy |
| cnt_coll | output | CNT_W | Attempts ended by collision |

## Verification
The bench rebuilds the expected wire image for every cycle of a packet from the byte array. A design that put the gap bit in the wrong place, sent the most significant bit first, or miscounted the L+2 bytes would therefore fail on the first differing cycle. It forces a foreign low on a chosen released bit, both in the length byte and in the trailing byte, and checks the exact abort edge. A design that sampled at the bit edge, or ignored the read-back, would end at the wrong time or report ok. A zero-length packet checks that the two framing bytes are still sent. A pre-driven attention line checks that the block neither claims the bus nor touches the data wire. A stray `start` pulse mid-packet would expose a design that restarts or counts twice.

// File: rtl/od_pkt_tx.sv
module od_pkt_tx #(
  parameter int BIT_CYCLES = 8,
  parameter int LEN_W      = 8,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [LEN_W:0]    mem_addr,
  input  logic [7:0]        mem_data,
  input  logic              attn_in,
  output logic              attn_drive_low,
  input  logic              line_in,
  output logic              line_drive_low,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [CNT_W-1:0]  cnt_ok,
  output logic [CNT_W-1:0]  cnt_busy,
  output logic [CNT_W-1:0]  cnt_coll
);

  localparam int ADDR_W = LEN_W + 1;
  localparam int TMR_W  = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(BIT_CYCLES - 1);
  localparam logic [TMR_W-1:0] TMR_MID  = TMR_W'(BIT_CYCLES / 2);
  localparam logic [1:0] ST_OK = 2'b00, ST_BUSY = 2'b01, ST_COLL = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_BYTE} state_t;

  state_t            state;
  logic [TMR_W-1:0]  tmr;
  logic [3:0]        slot;
  logic [ADDR_W-1:0] byte_idx;
  logic [ADDR_W-1:0] total;
  logic [7:0]        shreg;
  logic              attn_q;
  logic              done_q;
  logic [1:0]        status_q;

  wire bit_end   = (tmr == TMR_LAST);
  wire data_slot = (state == S_BYTE) && (slot >= 4'd2) && (slot <= 4'd9);
  wire collide   = data_slot && shreg[0] && (tmr == TMR_MID) && !line_in;
  wire last_byte = ((byte_idx + 1'b1) == total);

  assign mem_addr       = byte_idx;
  assign attn_drive_low = attn_q;
  assign line_drive_low = (state == S_BYTE) && ((slot == 4'd1) || (data_slot && !shreg[0]));
  assign busy           = (state != S_IDLE);
  assign done           = done_q;
  assign status         = status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tmr      <= '0;
      slot     <= '0;
      byte_idx <= '0;
      total    <= '0;
      shreg    <= '0;
      attn_q   <= 1'b0;
      done_q   <= 1'b0;
      status_q <= ST_OK;
      cnt_ok   <= '0;
      cnt_busy <= '0;
      cnt_coll <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (!attn_in) begin
              done_q   <= 1'b1;
              status_q <= ST_BUSY;
              cnt_busy <= cnt_busy + 1'b1;
            end else begin
              state    <= S_LEAD;
              attn_q   <= 1'b1;
              tmr      <= '0;
              slot     <= '0;
              byte_idx <= '0;
            end
          end
        end
        S_LEAD: begin
          tmr <= tmr + 1'b1;
          if (bit_end) begin
            tmr  <= '0;
            slot <= slot + 1'b1;
            if (slot == 4'd2) begin
              slot  <= '0;
              state <= S_BYTE;
            end
          end
        end
        S_BYTE: begin
          if (collide) begin
            state    <= S_IDLE;
            attn_q   <= 1'b0;
            done_q   <= 1'b1;
            status_q <= ST_COLL;
            cnt_coll <= cnt_coll + 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
            if (bit_end) begin
              tmr  <= '0;
              slot <= slot + 1'b1;
              if (slot == 4'd0) begin
                shreg <= mem_data;
                if (byte_idx == '0) total <= ADDR_W'(mem_data) + ADDR_W'(2);
              end
              if (data_slot) shreg <= {1'b0, shreg[7:1]};
              if (slot == 4'd10) begin
                slot <= '0;
                if (last_byte) begin
                  state    <= S_IDLE;
                  attn_q   <= 1'b0;
                  done_q   <= 1'b1;
                  status_q <= ST_OK;
                  cnt_ok   <= cnt_ok + 1'b1;
                end else begin
                  byte_idx <= byte_idx + 1'b1;
                end
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_busy_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && !attn_in) |=> (done && status == ST_BUSY && !attn_drive_low));

  a_r2_release_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(attn_drive_low) |-> done);

  a_r2_line_needs_claim: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive_low |-> attn_drive_low);

  a_r6_collision_seen_low: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_COLL) |-> $past(!line_in));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_ok_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_OK) |-> ((cnt_ok - $past(cnt_ok)) == CNT_W'(1)));

endmodule

// File: tb/od_pkt_tx_tb.sv
`timescale 1ns/1ps
module od_pkt_tx_tb;
  localparam int B = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [8:0] mem_addr;
  logic [7:0] mem_data;
  logic attn_drive_low, line_drive_low, busy, done;
  logic [1:0] status;
  logic [CW-1:0] cnt_ok, cnt_busy, cnt_coll;
  logic other_attn = 1'b0;
  logic force_low = 1'b0;
  logic [7:0] mem [0:511];

  wire attn_in = !(attn_drive_low || other_attn);
  wire line_in = !(line_drive_low || force_low);
  assign mem_data = mem[mem_addr];

  int tests = 0;
  int fails = 0;
  int m_ok = 0, m_busy = 0, m_coll = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  od_pkt_tx #(.BIT_CYCLES(B), .LEN_W(8), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr), .mem_data(mem_data),
    .attn_in(attn_in), .attn_drive_low(attn_drive_low), .line_in(line_in),
    .line_drive_low(line_drive_low), .busy(busy), .done(done), .status(status),
    .cnt_ok(cnt_ok), .cnt_busy(cnt_busy), .cnt_coll(cnt_coll)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // vector: {len, seed, collide_byte (255 = none)}
  localparam logic [23:0] VEC [6] = '{
    {8'd0, 8'h5A, 8'hFF},
    {8'd3, 8'hC3, 8'hFF},
    {8'd5, 8'h01, 8'hFF},
    {8'd2, 8'h80, 8'd1},
    {8'd4, 8'h3C, 8'd0},
    {8'd1, 8'hFF, 8'd2}
  };

  task automatic run_pkt(input int len, input logic [7:0] seed, input int cb,
                         input bit other, input bit poke);
    int n, t, t_done, exp_st, cbit, wire_err, attn_err, seen_t, seen_st;
    bit finished;
    n = len + 2;
    mem[0] = 8'(len);
    for (int i = 1; i < n; i++) mem[i] = seed ^ 8'(i * 37);
    cbit = -1;
    if (cb < n) begin
      for (int j = 7; j >= 0; j--) if (mem[cb][j]) cbit = j;
    end
    if (other) begin
      exp_st = 1; t_done = 0;
    end else if (cbit >= 0) begin
      exp_st = 2; t_done = 3*B + 11*B*cb + (2+cbit)*B + B/2 + 1;
    end else begin
      exp_st = 0; t_done = 3*B + 11*B*n;
    end
    wire_err = 0; attn_err = 0; seen_t = -1; seen_st = -1; finished = 0;
    @(negedge clk);
    other_attn = other;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!finished) begin
      logic exp_line, exp_attn;
      force_low = 1'b0;
      exp_line = 1'b0;
      if (exp_st != 1 && t >= 3*B && t < t_done) begin
        int rel, b, s;
        rel = t - 3*B;
        b = rel / (11*B);
        s = (rel % (11*B)) / B;
        if (exp_st == 2 && b == cb && s == 2 + cbit) force_low = 1'b1;
        if (s == 1) exp_line = 1'b1;
        else if (s >= 2 && s <= 9) exp_line = !mem[b][s-2];
      end
      exp_attn = (exp_st != 1) && (t < t_done);
      if (line_drive_low !== exp_line) wire_err++;
      if (attn_drive_low !== exp_attn) attn_err++;
      start = (poke && t == 20);
      if (done) begin
        seen_t = t; seen_st = int'(status); finished = 1;
      end else if (t > t_done + 20) begin
        finished = 1;
      end else begin
        @(posedge clk);
        @(negedge clk);
        t++;
      end
    end
    start = 1'b0;
    force_low = 1'b0;
    check(wire_err == 0, "R3 R4 R5 wire image mismatched cycles", wire_err, 0);
    check(attn_err == 0, (exp_st == 1) ? "R1 attention untouched" : "R2 attention hold/release", attn_err, 0);
    check(seen_t == t_done, (exp_st == 2) ? "R6 collision end edge" : "R7 done edge", seen_t, t_done);
    check(seen_st == exp_st, (exp_st == 1) ? "R1 busy status" : (exp_st == 2) ? "R6 collision status" : "R7 ok status", seen_st, exp_st);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R7 done lasts one cycle", int'(done), 0);
    other_attn = 1'b0;
    if (exp_st == 0) m_ok++;
    else if (exp_st == 1) m_busy++;
    else m_coll++;
    check(int'(cnt_ok) == m_ok && int'(cnt_busy) == m_busy && int'(cnt_coll) == m_coll,
          poke ? "R9 R8 counters after stray start" : "R8 counters",
          int'(cnt_ok)*10000 + int'(cnt_busy)*100 + int'(cnt_coll), m_ok*10000 + m_busy*100 + m_coll);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!line_drive_low && !attn_drive_low && !busy && !done && status == 2'b00,
          "R10 reset outputs", {line_drive_low, attn_drive_low, busy, done}, 0);
    check(cnt_ok == 0 && cnt_busy == 0 && cnt_coll == 0, "R10 reset counters",
          int'(cnt_ok) + int'(cnt_busy) + int'(cnt_coll), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int v = 0; v < 6; v++) begin
      logic [23:0] e;
      e = VEC[v];
      run_pkt(int'(e[23:16]), e[15:8], (e[7:0] == 8'hFF) ? 1000 : int'(e[7:0]), 1'b0, 1'b0);
    end

    // R1: bus already claimed by another node
    run_pkt(2, 8'h11, 1000, 1'b1, 1'b0);
    // R9: stray start mid-packet
    run_pkt(2, 8'h6B, 1000, 1'b0, 1'b1);
    // R5: longer packet
    run_pkt(9, 8'hA7, 1000, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule